// File: doc/BRIEF.md
# EEPROM Load Sequencer

This block executes a stored instruction image held in a byte-wide EEPROM. After a one-cycle start strobe it fetches the image one byte at a time from address zero upward and interprets each byte as an opcode. Block opcodes carry a register-map address and a run of data bytes, which the block writes to consecutive register-map addresses. Action opcodes fire one-cycle pulses toward the rest of the chip: soft update, calibration start and output sync. Condition opcodes and undefined codes are passed over. An end opcode finishes the load.

Every stored data run is followed by a checksum byte. The block keeps a running sum of the data bytes it has written and compares it with that byte. On a mismatch it raises a sticky error flag and abandons the load. Whether it ends at the end opcode or by abort, the read pointer returns to zero, so the next load starts again from the beginning of the image.

Two interfaces move data, and both use valid/ready. A read request (`ee_req_valid`, `ee_req_addr`) stays asserted with a stable address until `ee_req_ready` is seen. Only one request is ever outstanding. The read response (`ee_rsp_valid`, `ee_rsp_data`) has no ready: it is taken whenever it arrives while the block is waiting for a byte, and it is dropped at any other time. A register write (`reg_wr_valid`, address, data) stays stable until `reg_wr_ready` is seen. The block fetches no further byte while a write is stalled.

Top module: `eel_loader`

## Requirements
- R1: A `start` pulse while `busy` is low raises `busy` on the next cycle and clears `done` and `csum_err`. The first read request then carries address 0. A `start` pulse while `busy` is high has no effect on the load.
- R2: Reads go to consecutive addresses, one byte per accepted request, with at most one request outstanding. A request holds its valid and address until it is accepted.
- R3: An opcode from 0x00 to 0x7F announces a run of (opcode + 1) bytes. The next byte holds bits 15..8 of the register address and the byte after that holds bits 7..0. The data bytes follow and are written to ascending consecutive addresses, one write per handshake. Under back-pressure the address and data are held stable.
- R4: After the last data byte of a run, the block reads one checksum byte. The run is good when the 8-bit sum of its data bytes plus the checksum byte is zero, and the load then continues with the next byte as an opcode.
- R5: On a checksum mismatch, `csum_err` is set and stays set until the next accepted `start`. The load stops with `done` low, and the read pointer returns to 0.
- R6: Opcode 0x80 pulses `soft_upd`, 0xA0 pulses `cal_start` and 0xA1 pulses `out_sync`. Each pulse lasts exactly one cycle, and at most one of the three is high in any cycle.
- R7: Opcodes 0xB0 to 0xCF (condition selectors) and every other code from 0x81 to 0xFE except 0xA0 and 0xA1 are one-byte no-ops: they cause no write and no pulse.
- R8: Opcode 0xFF sets `done`, drops `busy` and returns the read pointer to 0. A repeated load of the same image therefore yields the same writes and pulses.
- R9: While `busy` is low, neither a read request nor a register write is issued.
- R10: After reset, `busy`, `done`, `csum_err`, all pulses and both valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a load |
| ee_req_valid | output | 1 | Read request valid |
| ee_req_ready | input | 1 | Read request accepted |
| ee_req_addr | output | EE_AW | Byte address of the read |
| ee_rsp_valid | input | 1 | Read data valid |
| ee_rsp_data | input | BW | Read data byte |
| reg_wr_valid | output | 1 | Register write valid |
| reg_wr_ready | input | 1 | Register write accepted |
| reg_wr_addr | output | 2*BW | Register write address |
| reg_wr_data | output | BW | Register write data |
| soft_upd | output | 1 | One-cycle soft update pulse |
| cal_start | output | 1 | One-cycle calibration start pulse |
| out_sync | output | 1 | One-cycle output sync pulse |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load ended at an end opcode |
| csum_err | output | 1 | Sticky checksum mismatch flag |

## Verification
The bench builds the block with EE_AW = 8 and BW = 8. The whole image then fits in a 256-byte model that the bench rewrites between loads. At that size a full 128-byte run (opcode 0x7F) still fits beside other instructions, together with its address bytes and checksum. Random ready patterns on both handshakes, combined with 1 to 3 cycles of read latency, drive the sequencer through every stall state. Repeated loads of an unchanged image exercise the pointer return after both a normal end and an abort.

// File: rtl/eel_pkg.sv
package eel_pkg;
  localparam logic [7:0] OPC_UPD  = 8'h80;
  localparam logic [7:0] OPC_CAL  = 8'hA0;
  localparam logic [7:0] OPC_SYNC = 8'hA1;
  localparam logic [7:0] OPC_CLO  = 8'hB0;
  localparam logic [7:0] OPC_CHI  = 8'hCF;
  localparam logic [7:0] OPC_END  = 8'hFF;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_WR} st_e;
  typedef enum logic [2:0] {PH_OP, PH_AHI, PH_ALO, PH_DAT, PH_SUM} ph_e;
  typedef enum logic [2:0] {OP_BLK, OP_UPD, OP_CAL, OP_SYNC, OP_COND, OP_END, OP_SKIP} op_e;
endpackage

// File: rtl/eel_decode.sv
module eel_decode
  import eel_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic [BW-1:0] code,
  output op_e           kind
);
  always_comb begin
    if (!code[BW-1])                                  kind = OP_BLK;
    else if (code == BW'(OPC_UPD))                    kind = OP_UPD;
    else if (code == BW'(OPC_CAL))                    kind = OP_CAL;
    else if (code == BW'(OPC_SYNC))                   kind = OP_SYNC;
    else if (code == BW'(OPC_END))                    kind = OP_END;
    else if (code >= BW'(OPC_CLO) && code <= BW'(OPC_CHI)) kind = OP_COND;
    else                                              kind = OP_SKIP;
  end
endmodule

// File: rtl/eel_fetch.sv
module eel_fetch #(
  parameter int EE_AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_en,
  input  logic             clr,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [EE_AW-1:0] req_addr,
  output logic             taken
);
  logic [EE_AW-1:0] ptr_q;

  assign req_valid = req_en;
  assign req_addr  = ptr_q;
  assign taken     = req_en && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (clr)   ptr_q <= '0;
    else if (taken) ptr_q <= ptr_q + 1'b1;
  end
endmodule

// File: rtl/eel_sum.sv
module eel_sum #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [BW-1:0] add_byte,
  input  logic [BW-1:0] chk_byte,
  output logic          match
);
  logic [BW-1:0] acc_q;
  logic [BW-1:0] total;

  assign total = acc_q + chk_byte;
  assign match = (total == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr)    acc_q <= '0;
    else if (add_en) acc_q <= acc_q + add_byte;
  end
endmodule

// File: rtl/eel_pulse.sv
module eel_pulse #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire,
  output logic [N-1:0] pulse
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[i] <= 1'b0;
      else        pulse[i] <= fire[i];
    end
  end
endmodule

// File: rtl/eel_loader.sv
module eel_loader
  import eel_pkg::*;
#(
  parameter int EE_AW = 10,
  parameter int BW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ee_req_valid,
  input  logic              ee_req_ready,
  output logic [EE_AW-1:0]  ee_req_addr,
  input  logic              ee_rsp_valid,
  input  logic [BW-1:0]     ee_rsp_data,
  output logic              reg_wr_valid,
  input  logic              reg_wr_ready,
  output logic [2*BW-1:0]   reg_wr_addr,
  output logic [BW-1:0]     reg_wr_data,
  output logic              soft_upd,
  output logic              cal_start,
  output logic              out_sync,
  output logic              busy,
  output logic              done,
  output logic              csum_err
);
  localparam int RA_W  = 2 * BW;
  localparam int N_ACT = 3;

  st_e             st_q;
  ph_e             ph_q;
  op_e             kind;
  logic [BW-1:0]   left_q;
  logic [RA_W-1:0] addr_q;
  logic [BW-1:0]   dat_q;
  logic            done_q, err_q;
  logic            taken, rsp_take, sum_ok, ptr_clr, wr_go;
  logic [N_ACT-1:0] act_fire, act_q;

  assign rsp_take = (st_q == ST_WAIT) && ee_rsp_valid;
  assign wr_go    = (st_q == ST_WR) && reg_wr_ready;
  assign ptr_clr  = rsp_take &&
                    (((ph_q == PH_OP) && (kind == OP_END)) ||
                     ((ph_q == PH_SUM) && !sum_ok));

  eel_decode #(.BW(BW)) u_dec (
    .code (ee_rsp_data),
    .kind (kind)
  );

  eel_fetch #(.EE_AW(EE_AW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_en    (st_q == ST_REQ),
    .clr       (ptr_clr),
    .req_ready (ee_req_ready),
    .req_valid (ee_req_valid),
    .req_addr  (ee_req_addr),
    .taken     (taken)
  );

  eel_sum #(.BW(BW)) u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rsp_take && (ph_q == PH_ALO)),
    .add_en   (wr_go),
    .add_byte (dat_q),
    .chk_byte (ee_rsp_data),
    .match    (sum_ok)
  );

  always_comb begin
    act_fire = '0;
    if (rsp_take && (ph_q == PH_OP)) begin
      act_fire[0] = (kind == OP_UPD);
      act_fire[1] = (kind == OP_CAL);
      act_fire[2] = (kind == OP_SYNC);
    end
  end

  eel_pulse #(.N(N_ACT)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (act_fire),
    .pulse (act_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_OP;
      left_q <= '0;
      addr_q <= '0;
      dat_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q   <= ST_REQ;
            ph_q   <= PH_OP;
            done_q <= 1'b0;
            err_q  <= 1'b0;
          end
        end
        ST_REQ: begin
          if (taken) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ee_rsp_valid) begin
            unique case (ph_q)
              PH_OP: begin
                if (kind == OP_BLK) begin
                  left_q <= {1'b0, ee_rsp_data[BW-2:0]} + 1'b1;
                  ph_q   <= PH_AHI;
                  st_q   <= ST_REQ;
                end else if (kind == OP_END) begin
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
                end else begin
                  st_q <= ST_REQ;
                end
              end
              PH_AHI: begin
                addr_q[RA_W-1:BW] <= ee_rsp_data;
                ph_q <= PH_ALO;
                st_q <= ST_REQ;
              end
              PH_ALO: begin
                addr_q[BW-1:0] <= ee_rsp_data;
                ph_q <= PH_DAT;
                st_q <= ST_REQ;
              end
              PH_DAT: begin
                dat_q <= ee_rsp_data;
                st_q  <= ST_WR;
              end
              PH_SUM: begin
                if (sum_ok) begin
                  ph_q <= PH_OP;
                  st_q <= ST_REQ;
                end else begin
                  err_q <= 1'b1;
                  ph_q  <= PH_OP;
                  st_q  <= ST_IDLE;
                end
              end
              default: st_q <= ST_IDLE;
            endcase
          end
        end
        ST_WR: begin
          if (reg_wr_ready) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == BW'(1)) ph_q <= PH_SUM;
            st_q <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign reg_wr_valid = (st_q == ST_WR);
  assign reg_wr_addr  = addr_q;
  assign reg_wr_data  = dat_q;
  assign soft_upd     = act_q[0];
  assign cal_start    = act_q[1];
  assign out_sync     = act_q[2];
  assign busy         = (st_q != ST_IDLE);
  assign done         = done_q;
  assign csum_err     = err_q;
endmodule

// File: rtl/eel_loader_chk.sv
module eel_loader_chk #(
  parameter int EE_AW = 10,
  parameter int BW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             ee_req_valid,
  input logic             ee_req_ready,
  input logic [EE_AW-1:0] ee_req_addr,
  input logic             reg_wr_valid,
  input logic             reg_wr_ready,
  input logic [2*BW-1:0]  reg_wr_addr,
  input logic [BW-1:0]    reg_wr_data,
  input logic             soft_upd,
  input logic             cal_start,
  input logic             out_sync,
  input logic             busy,
  input logic             done,
  input logic             csum_err
);
  AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && ee_req_valid && ee_req_addr == '0 && !done && !csum_err)); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req_valid && !ee_req_ready) |=> (ee_req_valid && $stable(ee_req_addr))); // R2

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_valid && !reg_wr_ready) |=> (reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data))); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (csum_err && !(start && !busy)) |=> csum_err); // R5

  AST_ACT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({soft_upd, cal_start, out_sync})); // R6

  AST_ACT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_upd || cal_start || out_sync) |=> !(soft_upd || cal_start || out_sync)); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_req_valid && !reg_wr_valid)); // R9
endmodule

bind eel_loader eel_loader_chk #(.EE_AW(EE_AW), .BW(BW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .ee_req_valid (ee_req_valid),
  .ee_req_ready (ee_req_ready),
  .ee_req_addr  (ee_req_addr),
  .reg_wr_valid (reg_wr_valid),
  .reg_wr_ready (reg_wr_ready),
  .reg_wr_addr  (reg_wr_addr),
  .reg_wr_data  (reg_wr_data),
  .soft_upd     (soft_upd),
  .cal_start    (cal_start),
  .out_sync     (out_sync),
  .busy         (busy),
  .done         (done),
  .csum_err     (csum_err)
);

// File: tb/sim_eel_loader.sv
module sim_eel_loader;
  localparam int EE_AW = 8;
  localparam int BW    = 8;
  localparam int unsigned EV_UPD  = 32'h0200_0000;
  localparam int unsigned EV_CAL  = 32'h0300_0000;
  localparam int unsigned EV_SYNC = 32'h0400_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start;
  logic ee_req_valid, ee_req_ready, ee_rsp_valid;
  logic [EE_AW-1:0] ee_req_addr;
  logic [7:0] ee_rsp_data;
  logic reg_wr_valid, reg_wr_ready;
  logic [15:0] reg_wr_addr;
  logic [7:0] reg_wr_data;
  logic soft_upd, cal_start, out_sync, busy, done, csum_err;

  eel_loader #(.EE_AW(EE_AW), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ee_req_valid(ee_req_valid), .ee_req_ready(ee_req_ready), .ee_req_addr(ee_req_addr),
    .ee_rsp_valid(ee_rsp_valid), .ee_rsp_data(ee_rsp_data),
    .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .soft_upd(soft_upd), .cal_start(cal_start), .out_sync(out_sync),
    .busy(busy), .done(done), .csum_err(csum_err)
  );

  logic [7:0] mem [0:255];
  int unsigned exp_q[$];
  int unsigned obs_q[$];
  int wp, exp_reads, rd_count, n_chk, n_fail, ee_bias, wr_bias;
  bit exp_done, exp_err, halted, addr_bad, idle_bad;

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned ev_wr(input int a, input logic [7:0] d);
    return 32'h0100_0000 | ((a & 32'hFFFF) << 8) | 32'(d);
  endfunction

  function automatic logic [7:0] rand_skip();
    logic [7:0] b;
    do b = 8'($urandom_range(8'h81, 8'hFE)); while (b == 8'hA0 || b == 8'hA1);
    return b;
  endfunction

  task automatic new_img();
    wp = 0; exp_q.delete(); exp_reads = 0;
    exp_done = 0; exp_err = 0; halted = 0;
  endtask

  task automatic put(input logic [7:0] b);
    mem[wp] = b; wp++;
    if (!halted) exp_reads++;
  endtask

  task automatic add_block(input int a, input int n, input bit bad);
    logic [7:0] s, d, c;
    s = 8'h00;
    put(8'(n - 1)); put(8'(a >> 8)); put(8'(a));
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      put(d);
      if (!halted) exp_q.push_back(ev_wr(a + i, d));
      s = s + d;
    end
    c = 8'h00 - s;
    if (bad) c = c + 8'h01;
    put(c);
    if (bad && !halted) begin exp_err = 1; halted = 1; end
  endtask

  task automatic add_act(input logic [7:0] code);
    put(code);
    if (!halted)
      exp_q.push_back(code == 8'h80 ? EV_UPD : (code == 8'hA0 ? EV_CAL : EV_SYNC));
  endtask

  task automatic add_end();
    put(8'hFF);
    if (!halted) exp_done = 1;
    halted = 1;
  endtask

  // memory model, write sink and monitor; all at the falling edge
  initial begin
    bit acc;
    int lat, paddr, acc_addr;
    acc = 0; lat = 0; paddr = 0; acc_addr = 0;
    ee_req_ready = 0; ee_rsp_valid = 0; ee_rsp_data = 0; reg_wr_ready = 0;
    forever begin
      @(negedge clk);
      ee_rsp_valid = 0;
      if (acc) begin lat = $urandom_range(1, 3); paddr = acc_addr; acc = 0; end
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin ee_rsp_valid = 1; ee_rsp_data = mem[paddr]; end
      end
      ee_req_ready = ($urandom_range(0, 99) < ee_bias);
      reg_wr_ready = ($urandom_range(0, 99) < wr_bias);
      if (rst_n && ee_req_valid && ee_req_ready) begin
        acc = 1; acc_addr = int'(ee_req_addr);
        if (acc_addr != (rd_count & 255)) addr_bad = 1;
        rd_count++;
      end
      if (rst_n && reg_wr_valid && reg_wr_ready) obs_q.push_back(ev_wr(int'(reg_wr_addr), reg_wr_data));
      if (soft_upd)  obs_q.push_back(EV_UPD);
      if (cal_start) obs_q.push_back(EV_CAL);
      if (out_sync)  obs_q.push_back(EV_SYNC);
      if (rst_n && !busy && (ee_req_valid || reg_wr_valid)) idle_bad = 1;
    end
  end

  task automatic run_load(input string tag, input string req, input bit poke);
    int cyc, bad_i;
    obs_q.delete(); rd_count = 0; addr_bad = 0; idle_bad = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(busy && !done && !csum_err, "R1", {tag, " busy/flags after start"},
          {busy, done, csum_err}, 3'b100);
    cyc = 0;
    while (busy && cyc < 20000) begin
      @(negedge clk); cyc++;
      start = poke && (cyc == 7) && busy;
    end
    start = 0;
    if (cyc >= 20000) begin
      check(0, "R8", {tag, " watchdog"}, cyc, 0);
      finish_up();
    end
    repeat (4) @(negedge clk);
    check(done == exp_done, exp_err ? "R5" : "R8", {tag, " done"}, done, exp_done);
    check(csum_err == exp_err, "R5", {tag, " csum_err"}, csum_err, exp_err);
    check(rd_count == exp_reads, "R2", {tag, " bytes read"}, rd_count, exp_reads);
    check(!addr_bad, "R2", {tag, " read address order"}, addr_bad, 0);
    check(!idle_bad, "R9", {tag, " idle activity"}, idle_bad, 0);
    check(obs_q.size() == exp_q.size(), req, {tag, " event count"}, obs_q.size(), exp_q.size());
    bad_i = -1;
    for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
      if (bad_i < 0 && obs_q[i] != exp_q[i]) bad_i = i;
    if (bad_i >= 0) check(0, req, {tag, " event"}, obs_q[bad_i], exp_q[bad_i]);
    else            check(1, req, {tag, " event"}, 0, 0);
  endtask

  task automatic rand_img();
    int n;
    new_img();
    n = $urandom_range(3, 12);
    for (int k = 0; k < n && wp < 200; k++) begin
      case ($urandom_range(0, 3))
        0: add_block($urandom_range(0, 16'hFF00), $urandom_range(1, 12), $urandom_range(0, 9) == 0);
        1: begin
          int s;
          s = $urandom_range(0, 2);
          add_act(s == 0 ? 8'h80 : (s == 1 ? 8'hA0 : 8'hA1));
        end
        2: put(rand_skip());
        default: put(8'(8'hB0 + $urandom_range(0, 31)));
      endcase
    end
    add_end();
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    n_chk = 0; n_fail = 0; ee_bias = 100; wr_bias = 100;
    rd_count = 0; addr_bad = 0; idle_bad = 0;
    rst_n = 0; start = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !csum_err, "R10", "flags in reset", {busy, done, csum_err}, 0);
    check(!soft_upd && !cal_start && !out_sync, "R10", "pulses in reset",
          {soft_upd, cal_start, out_sync}, 0);
    check(!ee_req_valid && !reg_wr_valid, "R10", "valids in reset",
          {ee_req_valid, reg_wr_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R3 R6: directed runs and all three actions
    new_img();
    add_block(16'h1234, 1, 0); add_act(8'h80); add_act(8'hA0); add_act(8'hA1);
    add_block(16'h00FE, 3, 0); add_end();
    run_load("directed", "R3", 0);

    // R7: conditions and undefined codes are skipped
    new_img();
    put(8'hB0); put(8'hB1); put(8'hC5); put(8'hCF); put(8'hFE);
    put(8'h81); put(8'h9F); put(8'hA2); put(8'hAF); put(8'hD0);
    add_block(16'h0040, 2, 0); add_end();
    run_load("skip codes", "R7", 0);

    // R8: same image again starts from address 0
    run_load("reload", "R8", 0);

    // R3 R4: longest run under back-pressure
    ee_bias = 60; wr_bias = 40;
    new_img();
    add_block(16'h0200, 128, 0); add_act(8'h80); add_end();
    run_load("max run", "R4", 0);

    // R5: bad checksum aborts, later opcodes not executed
    new_img();
    add_block(16'h0010, 4, 0); add_block(16'h0020, 2, 1); add_act(8'h80); add_end();
    run_load("bad checksum", "R5", 0);
    repeat (5) @(negedge clk);
    check(csum_err && !busy, "R5", "error held while idle", csum_err, 1);

    // R1 R5: next load clears the error and restarts at 0
    new_img();
    add_act(8'hA1); add_block(16'hABCD, 5, 0); add_end();
    run_load("after abort", "R1", 0);

    // R1: start while busy is ignored
    rand_img();
    run_load("start while busy", "R1", 1);

    // random images with random stalls
    for (int t = 0; t < 25; t++) begin
      ee_bias = $urandom_range(30, 100);
      wr_bias = $urandom_range(30, 100);
      rand_img();
      run_load($sformatf("random %0d", t), "R3", $urandom_range(0, 1));
    end

    finish_up();
  end

  initial begin
    #(200000 * 20);
    check(0, "R8", "global watchdog", 0, 1);
    finish_up();
  end
endmodule